// File: doc/BRIEF.md
# Root Hub Port Change Bitmap

This block takes the change flags of a root hub's downstream ports and turns them into the packed status-change bitmap that a hub reports to its host. Each port supplies three flags: connection changed, enable changed and over-current changed. A port counts as changed when any of its three flags is set.

In the bitmap, position 0 belongs to the hub itself and is always clear. Port i, counting from 0, takes position i+1. The bitmap is a whole number of bytes, and the block reports how many of those bytes are valid: zero when no port has a change, and the full length otherwise.

The block also gives an "any change" level and a one-cycle pulse when that level rises. Other logic can use the pulse to start a status report. All outputs come from registers, so each one follows its inputs by one clock.

Top module: `hub_change_map`

## Requirements
- R1: A port is marked as changed when at least one of its connection-change, enable-change or over-current-change inputs is 1. With all three at 0 it is not marked.
- R2: The change mark of port i (0-based) is at bitmap position i+1, that is byte (i+1)/8, bit (i+1) mod 8 of `chg_map`.
- R3: Bitmap position 0, the hub's own entry, always reads 0.
- R4: Every bitmap position above NUM_PORTS, up to the end of the last byte, reads 0.
- R5: `map_len` equals (NUM_PORTS+8)/8 (integer division) when at least one port is marked, and 0 when none is.
- R6: `any_chg` is 1 exactly when at least one port is marked.
- R7: `chg_map`, `map_len`, `any_chg` and `chg_pulse` reflect the inputs sampled at the previous rising clock edge.
- R8: `chg_pulse` is 1 for exactly the one cycle in which `any_chg` goes from 0 to 1. It stays 0 while `any_chg` holds at 1 or falls.
- R9: While `rst` is high and on the cycle after it is released, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| conn_chg | input | NUM_PORTS | Connection-change flag per port |
| en_chg | input | NUM_PORTS | Enable-change flag per port |
| oc_chg | input | NUM_PORTS | Over-current-change flag per port |
| chg_map | output | 8*((NUM_PORTS+8)/8) | Registered change bitmap, position 0 is the hub |
| map_len | output | clog2(bytes+1) | Valid bitmap length in bytes |
| any_chg | output | 1 | At least one port has a change |
| chg_pulse | output | 1 | One-cycle pulse when `any_chg` rises |

## Verification
The bench uses nine ports, so the bitmap spans two bytes and port 7 crosses the byte boundary. A single flag is walked over every port and every flag type. This separates placement errors (off-by-one shifts, wrong byte) from errors in merging the three flags. Every flag combination on the first and last port is then swept, along with pseudo-random multi-port patterns.

Some patterns are repeated and some are broken up by all-zero inputs. Holding a pattern shows whether the pulse fires only on a rise. The all-zero patterns show that the length drops to zero.

// File: rtl/hub_map_pkg.sv
package hub_map_pkg;
  // Number of bytes in the bitmap: one hub position plus one per port.
  function automatic int map_bytes(input int ports);
    return (ports + 8) / 8;
  endfunction

  // Width of the byte-count field, able to hold the full length.
  function automatic int len_bits(input int ports);
    return $clog2(map_bytes(ports) + 1);
  endfunction
endpackage

// File: rtl/port_flag_merge.sv
module port_flag_merge #(
  parameter int NUM_PORTS = 9
) (
  input  logic [NUM_PORTS-1:0] conn_chg,
  input  logic [NUM_PORTS-1:0] en_chg,
  input  logic [NUM_PORTS-1:0] oc_chg,
  output logic [NUM_PORTS-1:0] port_mark
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_mark[p] = conn_chg[p] | en_chg[p] | oc_chg[p];
  end
endmodule

// File: rtl/map_pack.sv
module map_pack #(
  parameter int NUM_PORTS = 9,
  parameter int MAP_W     = 16
) (
  input  logic [NUM_PORTS-1:0] port_mark,
  output logic [MAP_W-1:0]     map_next,
  output logic                 any_next
);
  // Position 0 is the hub, never set.
  assign map_next[0] = 1'b0;

  for (genvar b = 1; b < MAP_W; b++) begin : g_pos
    if (b <= NUM_PORTS) begin : g_port
      assign map_next[b] = port_mark[b-1];
    end else begin : g_pad
      assign map_next[b] = 1'b0;
    end
  end

  assign any_next = |port_mark;
endmodule

// File: rtl/change_out_reg.sv
module change_out_reg #(
  parameter int MAP_W     = 16,
  parameter int LEN_W     = 2,
  parameter int MAP_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAP_W-1:0] map_next,
  input  logic             any_next,
  output logic [MAP_W-1:0] map_q,
  output logic [LEN_W-1:0] len_q,
  output logic             any_q,
  output logic             pulse_q
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAP_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q   <= '0;
      len_q   <= '0;
      any_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      map_q   <= map_next;
      len_q   <= any_next ? FULL_LEN : '0;
      any_q   <= any_next;
      pulse_q <= any_next & ~any_q;
    end
  end

  // R8: a pulse only with a newly raised change level
  a_r8_pulse_level: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (any_q && !$past(any_q)));
  // R8: every rise of the level is accompanied by a pulse
  a_r8_rise_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(any_q) |-> pulse_q);
  // R5: length agrees with the level
  a_r5_len_match: assert property (@(posedge clk) disable iff (rst)
    len_q == (any_q ? FULL_LEN : '0));
endmodule

// File: rtl/hub_change_map.sv
module hub_change_map
  import hub_map_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  localparam int MAP_BYTES = map_bytes(NUM_PORTS),
  localparam int MAP_W     = 8 * MAP_BYTES,
  localparam int LEN_W     = len_bits(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] conn_chg,
  input  logic [NUM_PORTS-1:0] en_chg,
  input  logic [NUM_PORTS-1:0] oc_chg,
  output logic [MAP_W-1:0]     chg_map,
  output logic [LEN_W-1:0]     map_len,
  output logic                 any_chg,
  output logic                 chg_pulse
);
  logic [NUM_PORTS-1:0] port_mark;
  logic [MAP_W-1:0]     map_next;
  logic                 any_next;

  port_flag_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .conn_chg (conn_chg),
    .en_chg   (en_chg),
    .oc_chg   (oc_chg),
    .port_mark(port_mark)
  );

  map_pack #(.NUM_PORTS(NUM_PORTS), .MAP_W(MAP_W)) u_pack (
    .port_mark(port_mark),
    .map_next (map_next),
    .any_next (any_next)
  );

  change_out_reg #(.MAP_W(MAP_W), .LEN_W(LEN_W), .MAP_BYTES(MAP_BYTES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .map_next(map_next),
    .any_next(any_next),
    .map_q   (chg_map),
    .len_q   (map_len),
    .any_q   (any_chg),
    .pulse_q (chg_pulse)
  );

  // R3: hub position stays clear
  a_r3_hub_bit_zero: assert property (@(posedge clk) disable iff (rst)
    chg_map[0] == 1'b0);
  // R4: padding above the last port stays clear
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (chg_map >> (NUM_PORTS + 1)) == '0);
  // R6: level matches the registered bitmap
  a_r6_any_map: assert property (@(posedge clk) disable iff (rst)
    any_chg == (chg_map != '0));
endmodule

// File: tb/hub_change_map_test.sv
module hub_change_map_test;
  localparam int NP      = 9;
  localparam int BYTES   = (NP + 8) / 8;
  localparam int MW      = 8 * BYTES;
  localparam int LW      = $clog2(BYTES + 1);
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] conn_chg = '0, en_chg = '0, oc_chg = '0;
  logic [MW-1:0] chg_map;
  logic [LW-1:0] map_len;
  logic          any_chg, chg_pulse;

  int checks = 0;
  int errors = 0;
  logic prev_any = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  hub_change_map #(.NUM_PORTS(NP)) uut (
    .clk(clk), .rst(rst), .conn_chg(conn_chg), .en_chg(en_chg),
    .oc_chg(oc_chg), .chg_map(chg_map), .map_len(map_len),
    .any_chg(any_chg), .chg_pulse(chg_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R7: inputs applied after a falling edge appear after the next rising edge
  task automatic apply(input logic [NP-1:0] c, input logic [NP-1:0] e,
                       input logic [NP-1:0] o);
    int exp_map;
    int any_e;
    @(negedge clk);
    conn_chg = c; en_chg = e; oc_chg = o;
    @(posedge clk);
    #1;
    exp_map = 0;
    for (int i = 0; i < NP; i++)
      if (c[i] || e[i] || o[i]) exp_map = exp_map | (1 << (i + 1));  // R1 R2
    any_e = (exp_map != 0) ? 1 : 0;
    chk("R1/R2/R3/R4 map R7", int'(chg_map), exp_map);
    chk("R5 len", int'(map_len), any_e ? BYTES : 0);
    chk("R6 any", int'(any_chg), any_e);
    chk("R8 pulse", int'(chg_pulse), (any_e == 1 && prev_any == 1'b0) ? 1 : 0);
    prev_any = any_e[0];
  endtask

  initial begin
    #(CLK_PER * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2B5D;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 map", int'(chg_map), 0);
    chk("R9 len", int'(map_len), 0);
    chk("R9 any", int'(any_chg), 0);
    chk("R9 pulse", int'(chg_pulse), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 after release", int'({chg_map, map_len, any_chg, chg_pulse}), 0);
    prev_any = 1'b0;

    // R1 R2: walk one flag of each type over every port, zero between
    for (int f = 0; f < 3; f++) begin
      for (int p = 0; p < NP; p++) begin
        logic [NP-1:0] one;
        one = NP'(1) << p;
        apply(f == 0 ? one : '0, f == 1 ? one : '0, f == 2 ? one : '0);
        apply(f == 0 ? one : '0, f == 1 ? one : '0, f == 2 ? one : '0); // R8 hold
        apply('0, '0, '0);                                              // R5 zero len
      end
    end

    // R1: all flag combinations on the first and last ports
    for (int v = 0; v < 64; v++) begin
      logic [NP-1:0] c, e, o;
      c = '0; e = '0; o = '0;
      c[0] = v[0]; e[0] = v[1]; o[0] = v[2];
      c[NP-1] = v[3]; e[NP-1] = v[4]; o[NP-1] = v[5];
      apply(c, e, o);
    end

    // Pseudo-random multi-port patterns, with occasional quiet cycles
    for (int k = 0; k < 600; k++) begin
      logic [NP-1:0] c, e, o;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      c = lfsr[NP-1:0] & lfsr[NP+10:11];
      e = lfsr[NP+4:5] & lfsr[NP+20:21];
      o = lfsr[NP+13:14] & lfsr[NP-1+2:2] & lfsr[NP+7:8];
      if (lfsr[31:30] == 2'b00) apply('0, '0, '0);
      else apply(c, e, o);
    end

    // R8: rise straight from a quiet state after a fall
    apply('1, '1, '1);
    apply('0, '0, '0);
    apply('0, '0, NP'(1) << (NP - 1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule